// File: doc/BRIEF.md
# SD Card Clock, Power and Bus-Width Control

This block turns the system clock into the card clock that drives an SD or MMC card. It divides the system clock by a programmable even ratio and can stop the card clock without producing a runt pulse. The same block holds the card power switch with its supply voltage code, and the data bus width selection. The bus width register also carries read-only capability bits, fixed at build time, that tell software which bus widths the card slot is wired for.

Software programs the block through a simple write port at three fixed byte offsets: 52 for power, 56 for clock and 60 for bus width. A combinational read port returns the stored fields at the same offsets. The outputs go straight to the card-side logic: the card clock, a power enable with a 4-bit voltage code, the SD-mode and high-speed mode flags, and a one-hot width select. Pad drivers and voltage regulation sit outside this block.

Top module: `sd_clkpwr_ctrl`

## Requirements
- R1: With divider field value d, each high phase and each low phase of `card_clk` lasts d+1 system clocks, so the period is 2*(d+1). The value d=0 gives a period of 2.
- R2: The clock register at offset 56 holds the divider in bits [6:0], SD mode in bit 7 (drives `card_sd_mode`), clock-off in bit 8 and high speed in bit 9 (drives `card_hispd`). A read at offset 56 returns these ten bits with zeros above them.
- R3: Setting clock-off while `card_clk` is high lets the high phase run to its full length, and the clock then stays low for as long as clock-off is set. After clock-off is cleared, `card_clk` rises d+1 system clocks after the clearing write is registered.
- R4: A new divider value written during a high phase does not shorten or stretch that phase. It takes effect from the following low phase, so the change is applied at the falling edge that closes the current card clock period.
- R5: The power register at offset 52 holds the power enable in bit 4 (drives `card_pwr_en`) and the voltage code in bits [3:0] (drives `card_vcode`). Higher write bits are dropped. A read returns these five bits.
- R6: Bus width is written one-hot to offset 60: bit 0 selects 1-bit, bit 1 selects 4-bit and bit 2 selects 8-bit. `bus_sel` shows the stored value with the same bit meaning, and a read at offset 60 returns it in bits [2:0].
- R7: Bits [4:3] at offset 60 read as the build-time capability code: 0 for 1-bit only, 1 for up to 4-bit, 2 for up to 8-bit. Writes to those bits are ignored.
- R8: A bus width write that has zero or more than one bit set in [2:0], or that selects a width the capability code does not allow, leaves `bus_sel` unchanged.
- R9: After reset, power is off with voltage code 0, `bus_sel` is 1-bit (3'b001), the divider is 127, clock-off, SD mode and high speed are 0, and `card_clk` is low.
- R10: Writes to any offset other than 52, 56 and 60 change nothing, and reads at such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| card_clk | output | 1 | Divided and gated card clock |
| card_pwr_en | output | 1 | Card power switch enable |
| card_vcode | output | 4 | Card supply voltage code |
| card_sd_mode | output | 1 | SD mode flag from the clock register |
| card_hispd | output | 1 | High-speed flag from the clock register |
| bus_sel | output | 3 | One-hot data bus width select |

## Verification
The hardest situations to reach from the ports are a divider change or a clock-off request that lands in the middle of a high phase. Card clock edges are only visible as sampled levels, so the stimulus first aligns to the first sample of a high phase and issues the write in that same cycle. It then counts the lengths of the following phases, expecting the old length first and the new behaviour after it. A second instance built with capability code 0 shows that width requests are refused when the slot does not support them.

// File: rtl/sdcp_pkg.sv
// Package: shared constants and field types for the SD clock/power/width
// control block. Assumes byte offsets fit in the address width used by the top.
package sdcp_pkg;
    localparam int DIV_W       = 7;   // divider field width
    localparam int VCODE_W     = 4;   // voltage code width
    localparam int WSEL_N      = 3;   // number of one-hot width selects
    localparam int CAP_W       = 2;   // capability code width
    localparam int OFS_PWR     = 52;  // power register offset
    localparam int OFS_CLK     = 56;  // clock register offset
    localparam int OFS_BUS     = 60;  // bus width register offset
    localparam int CLK_SD_BIT  = 7;
    localparam int CLK_OFF_BIT = 8;
    localparam int CLK_HS_BIT  = 9;
    localparam int PWR_ON_BIT  = 4;

    // Packed order matches the readback layout at the clock offset
    typedef struct packed {
        logic             hispd;
        logic             gate_off;
        logic             sd_mode;
        logic [DIV_W-1:0] div;
    } clkcfg_t;

    // Packed order matches the readback layout at the power offset
    typedef struct packed {
        logic               on;
        logic [VCODE_W-1:0] code;
    } pwrcfg_t;
endpackage

// File: rtl/sdcp_ctlregs.sv
// Module: clock and power configuration registers.
// Decodes writes to the clock and power offsets and holds the fields.
// Assumes a single-cycle write strobe with address and data valid alongside.
module sdcp_ctlregs
    import sdcp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output clkcfg_t           clk_cfg,
    output pwrcfg_t           pwr_cfg
);
    logic hit_clk;
    logic hit_pwr;

    // Address decode of the two writable offsets
    always_comb begin
        hit_clk = wr_en && (wr_addr == ADDR_W'(OFS_CLK));
        hit_pwr = wr_en && (wr_addr == ADDR_W'(OFS_PWR));
    end

    // Clock configuration register; reset leaves the slowest divider
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_cfg.hispd    <= 1'b0;
            clk_cfg.gate_off <= 1'b0;
            clk_cfg.sd_mode  <= 1'b0;
            clk_cfg.div      <= '1;
        end else if (hit_clk) begin
            clk_cfg.hispd    <= wr_data[CLK_HS_BIT];
            clk_cfg.gate_off <= wr_data[CLK_OFF_BIT];
            clk_cfg.sd_mode  <= wr_data[CLK_SD_BIT];
            clk_cfg.div      <= wr_data[DIV_W-1:0];
        end
    end

    // Power configuration register; reset leaves the card unpowered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_cfg <= '0;
        end else if (hit_pwr) begin
            pwr_cfg.on   <= wr_data[PWR_ON_BIT];
            pwr_cfg.code <= wr_data[VCODE_W-1:0];
        end
    end

    AST_PWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == ADDR_W'(OFS_PWR))) |=> $stable(pwr_cfg)); // R5

    AST_CLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == ADDR_W'(OFS_CLK))) |=> $stable(clk_cfg)); // R10
endmodule

// File: rtl/sdcp_buswidth.sv
// Module: bus width select register.
// Accepts a write only when exactly one width bit is set and that width is
// allowed by the build-time capability code (0: 1-bit, 1: up to 4, 2: up to 8).
module sdcp_buswidth
    import sdcp_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CAP_CODE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [WSEL_N-1:0] bus_sel
);
    logic [WSEL_N-1:0] ok_mask;
    logic [WSEL_N-1:0] req;
    logic              hit;
    logic              req_onehot;
    logic              accept;

    // Per-lane support flag: lane g is allowed when the capability reaches g
    for (genvar g = 0; g < WSEL_N; g++) begin : g_lane
        assign ok_mask[g] = (CAP_CODE >= g);
    end

    // Validate the requested width against one-hot form and capability
    always_comb begin
        hit        = wr_en && (wr_addr == ADDR_W'(OFS_BUS));
        req        = wr_data[WSEL_N-1:0];
        req_onehot = (req != '0) && ((req & (req - 1'b1)) == '0);
        accept     = hit && req_onehot && ((req & ~ok_mask) == '0);
    end

    // Width select register; reset selects the 1-bit bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_sel <= WSEL_N'(1);
        end else if (accept) begin
            bus_sel <= req;
        end
    end

    AST_BUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bus_sel) == 1); // R6

    AST_BUS_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == ADDR_W'(OFS_BUS)) &&
         ($countones(wr_data[WSEL_N-1:0]) != 1)) |=> $stable(bus_sel)); // R8
endmodule

// File: rtl/sdcp_clkgen.sv
// Module: card clock divider with glitch-free gating.
// Each card clock phase lasts div+1 system clocks. A new divider is taken at
// the falling edge that ends a period, or continuously while stopped low.
// Gating only holds the clock when it is already low, so no pulse is cut.
module sdcp_clkgen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_req,
    input  logic             gate_off,
    output logic             card_clk
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_act;
    logic             clk_q;

    // Phase counter, output toggle and period-aligned divider update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            div_act <= '1;
            clk_q   <= 1'b0;
        end else if (gate_off && !clk_q) begin
            cnt     <= '0;
            div_act <= div_req;
        end else if (cnt == div_act) begin
            cnt   <= '0;
            clk_q <= ~clk_q;
            if (clk_q) begin
                div_act <= div_req;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign card_clk = clk_q;

    AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_off && !clk_q) |=> !clk_q); // R3

    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_q) |-> ($past(cnt) == $past(div_act))); // R3

    AST_PHASE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= div_act); // R1

    AST_DIV_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (div_act != $past(div_act)) |-> !clk_q); // R4
endmodule

// File: rtl/sd_clkpwr_ctrl.sv
// Module: top of the SD card clock, power and bus width control block.
// Joins the configuration registers, the width register and the clock
// divider, and provides a combinational readback port. Assumes CAP_CODE is
// 0, 1 or 2 and that register offsets fit in ADDR_W bits.
module sd_clkpwr_ctrl
    import sdcp_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CAP_CODE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               card_clk,
    output logic               card_pwr_en,
    output logic [VCODE_W-1:0] card_vcode,
    output logic               card_sd_mode,
    output logic               card_hispd,
    output logic [WSEL_N-1:0]  bus_sel
);
    localparam logic [CAP_W-1:0] CAP_BITS = CAP_W'(CAP_CODE);

    clkcfg_t clk_cfg;
    pwrcfg_t pwr_cfg;

    sdcp_ctlregs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctlregs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .clk_cfg (clk_cfg),
        .pwr_cfg (pwr_cfg)
    );

    sdcp_buswidth #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CAP_CODE (CAP_CODE)
    ) u_buswidth (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bus_sel (bus_sel)
    );

    sdcp_clkgen #(
        .DIV_W (DIV_W)
    ) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_req  (clk_cfg.div),
        .gate_off (clk_cfg.gate_off),
        .card_clk (card_clk)
    );

    // Card-side field outputs
    assign card_pwr_en  = pwr_cfg.on;
    assign card_vcode   = pwr_cfg.code;
    assign card_sd_mode = clk_cfg.sd_mode;
    assign card_hispd   = clk_cfg.hispd;

    // Readback multiplexer; unmapped offsets read as zero
    always_comb begin
        case (rd_addr)
            ADDR_W'(OFS_PWR): rd_data = DATA_W'(pwr_cfg);
            ADDR_W'(OFS_CLK): rd_data = DATA_W'(clk_cfg);
            ADDR_W'(OFS_BUS): rd_data = DATA_W'({CAP_BITS, bus_sel});
            default:          rd_data = '0;
        endcase
    end

    AST_PWR_OFF_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> (!card_pwr_en && (card_vcode == '0))); // R9
endmodule

// File: tb/sd_clkpwr_ctrl_tb.sv
module sd_clkpwr_ctrl_tb;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NV = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data, rd_data_c0;
    logic          card_clk, card_clk_c0;
    logic          card_pwr_en, card_pwr_en_c0;
    logic [3:0]    card_vcode, card_vcode_c0;
    logic          card_sd_mode, card_sd_mode_c0;
    logic          card_hispd, card_hispd_c0;
    logic [2:0]    bus_sel, bus_sel_c0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sd_clkpwr_ctrl #(.CAP_CODE(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .card_clk(card_clk), .card_pwr_en(card_pwr_en), .card_vcode(card_vcode),
        .card_sd_mode(card_sd_mode), .card_hispd(card_hispd), .bus_sel(bus_sel)
    );

    sd_clkpwr_ctrl #(.CAP_CODE(0)) u_dut_c0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_c0),
        .card_clk(card_clk_c0), .card_pwr_en(card_pwr_en_c0),
        .card_vcode(card_vcode_c0), .card_sd_mode(card_sd_mode_c0),
        .card_hispd(card_hispd_c0), .bus_sel(bus_sel_c0)
    );

    // Row: {req, addr, wdata, expected readback, expected {pwr_en, vcode, bus_sel}}
    localparam logic [87:0] VEC [NV] = '{
        {8'd5,  8'd52, 32'h0000_001A, 32'h0000_001A, 8'hD1}, // R5 power on, code A
        {8'd5,  8'd52, 32'hFFFF_FF05, 32'h0000_0005, 8'h29}, // R5 high bits dropped
        {8'd6,  8'd60, 32'h0000_0002, 32'h0000_0012, 8'h2A}, // R6 4-bit
        {8'd6,  8'd60, 32'h0000_0004, 32'h0000_0014, 8'h2C}, // R6 8-bit
        {8'd8,  8'd60, 32'h0000_0006, 32'h0000_0014, 8'h2C}, // R8 two bits set
        {8'd8,  8'd60, 32'h0000_0000, 32'h0000_0014, 8'h2C}, // R8 no bit set
        {8'd7,  8'd60, 32'h0000_0019, 32'h0000_0011, 8'h29}, // R7 cap bits not writable
        {8'd2,  8'd56, 32'h0000_0283, 32'h0000_0283, 8'h29}, // R2 fields
        {8'd10, 8'd64, 32'hFFFF_FFFF, 32'h0000_0000, 8'h29}, // R10 unmapped offset
        {8'd5,  8'd52, 32'h0000_0010, 32'h0000_0010, 8'h81}, // R5 code 0, on
        {8'd2,  8'd56, 32'hFFFF_FC7F, 32'h0000_007F, 8'h81}  // R2 upper bits dropped
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [AW-1:0] a);
        rd_addr = a;
        #1;
    endtask

    // Counts samples of the current card clock level, returning at the first new level
    task automatic phase_len(output int n);
        logic v;
        v = card_clk;
        n = 0;
        while (card_clk === v && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Lands on the first sample of a high phase
    task automatic sync_high();
        int n;
        phase_len(n);
        phase_len(n);
        while (card_clk !== 1'b1) phase_len(n);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        bit stuck;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check("R9 card_clk", 32'(card_clk), 32'h0);
        check("R9 outputs", 32'({card_pwr_en, card_vcode, bus_sel}), 32'h01);
        check("R9 mode flags", 32'({card_sd_mode, card_hispd}), 32'h0);
        reg_rd(8'd56); check("R9 clock reg", rd_data, 32'h7F);
        reg_rd(8'd52); check("R9 power reg", rd_data, 32'h0);
        reg_rd(8'd60); check("R9 width reg", rd_data, 32'h11);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            reg_wr(VEC[i][79:72], VEC[i][71:40]);
            reg_rd(VEC[i][79:72]);
            check($sformatf("row %0d R%0d readback", i, VEC[i][87:80]), rd_data, VEC[i][39:8]);
            check($sformatf("row %0d R%0d outputs", i, VEC[i][87:80]),
                  32'({card_pwr_en, card_vcode, bus_sel}), 32'(VEC[i][7:0]));
        end

        // R2 mode flags and R1 divider 3
        reg_wr(8'd56, 32'h283);
        check("R2 sd/hispd set", 32'({card_sd_mode, card_hispd}), 32'h3);
        sync_high();
        phase_len(n); check("R1 d=3 high", 32'(n), 32'd4);
        phase_len(n); check("R1 d=3 low", 32'(n), 32'd4);

        // R4 divider change during a high phase
        reg_wr(8'd56, 32'h5);
        check("R2 sd/hispd clear", 32'({card_sd_mode, card_hispd}), 32'h0);
        sync_high();
        phase_len(n); phase_len(n);
        check("R1 d=5 high", 32'(n), 32'd6);
        wr_addr = 8'd56; wr_data = 32'h1; wr_en = 1'b1; n = 0;
        do begin n++; @(negedge clk); wr_en = 1'b0; end while (card_clk === 1'b1 && n < 2000);
        check("R4 current high kept", 32'(n), 32'd6);
        phase_len(n); check("R4 next low new div", 32'(n), 32'd2);
        phase_len(n); check("R4 next high new div", 32'(n), 32'd2);

        // R3 gating while high
        reg_wr(8'd56, 32'h3);
        sync_high();
        phase_len(n); phase_len(n);
        wr_addr = 8'd56; wr_data = 32'h103; wr_en = 1'b1; n = 0;
        do begin n++; @(negedge clk); wr_en = 1'b0; end while (card_clk === 1'b1 && n < 2000);
        check("R3 high not cut", 32'(n), 32'd4);
        stuck = 1'b1;
        for (int k = 0; k < 40; k++) begin
            if (card_clk !== 1'b0) stuck = 1'b0;
            @(negedge clk);
        end
        check("R3 held low", 32'(stuck), 32'h1);
        // clear write sample plus d+1 low cycles after it registers: 1 + 4
        wr_addr = 8'd56; wr_data = 32'h3; wr_en = 1'b1; n = 0;
        do begin n++; @(negedge clk); wr_en = 1'b0; end while (card_clk === 1'b0 && n < 2000);
        check("R3 restart low", 32'(n), 32'd5);
        phase_len(n); check("R3 first high", 32'(n), 32'd4);

        // R1 fastest divider
        reg_wr(8'd56, 32'h0);
        sync_high();
        phase_len(n); check("R1 d=0 high", 32'(n), 32'd1);
        phase_len(n); check("R1 d=0 low", 32'(n), 32'd1);

        // R7 and R8 with capability code 0
        reg_rd(8'd60); check("R7 cap0 readback", rd_data_c0, 32'h01);
        reg_wr(8'd60, 32'h2);
        check("R8 cap0 rejects 4-bit", 32'(bus_sel_c0), 32'h1);
        check("R6 cap2 accepts 4-bit", 32'(bus_sel), 32'h2);
        reg_wr(8'd60, 32'h4);
        check("R8 cap0 rejects 8-bit", 32'(bus_sel_c0), 32'h1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule